// File: doc/BRIEF.md
# Debug mode entry and activation controller

This controller decides when a processor core may enter its background debug state and when it leaves it. It holds a single enable flag, written by a debug-port byte write to a fixed status location. While the flag is set, three sources can pull the core into debug state. An instruction tag hit and an executed breakpoint opcode take effect on the very next cycle. A debug-port BACKGROUND command waits for the next instruction boundary.

A request that arrives while the flag is clear is refused. The controller then raises a busy indication for a fixed number of cycles, after which normal execution carries on. While debug state is active, the controller drives a signal that lays the debug ROM and registers over the top page of the address space. It also drives a decode of the small control-register window and a freeze output for peripherals such as timers. A return command ends debug state at a later instruction boundary. When the part boots in special single-chip mode, the flag is set and debug state is active straight out of reset.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: A write strobe with address 0xFF01 loads the enable flag from data bit 7, seen on `dbg_enable` the next cycle; writes to any other address leave the flag unchanged.
- R2: With the flag set and debug state inactive, `tag_hit` makes `dbg_active` high on the next cycle.
- R3: With the flag set and debug state inactive, `bgnd_op` makes `dbg_active` high on the next cycle.
- R4: With the flag set, `bg_cmd` is held pending. `dbg_active` rises the cycle after the first `insn_bound` that falls strictly after the command cycle. A boundary in the same cycle as the command does not count.
- R5: Any request while the flag is clear leaves `dbg_active` low. `ign_busy` is then high for exactly IGN_CYCLES (16) cycles, starting the cycle after the request. Further requests during that window neither restart nor lengthen it.
- R6: When `boot_special` is high during reset, `dbg_enable` and `dbg_active` are high from the first cycle after reset.
- R7: `map_en` equals `dbg_active`. `map_hit` is high exactly when debug state is active and `cpu_addr` lies in 0xFF00–0xFFFF. `ctrl_hit` is high exactly when debug state is active and `cpu_addr` lies in 0xFF00–0xFF06.
- R8: `go_cmd` during debug state is held pending. `dbg_active` falls the cycle after the first `insn_bound` strictly after the command cycle.
- R9: `freeze` is high in exactly the cycles in which `dbg_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_special | input | 1 | Special single-chip boot mode, sampled during reset |
| reg_wr | input | 1 | Debug-port register write strobe |
| reg_addr | input | 16 | Address of the debug-port write |
| reg_wdata | input | 8 | Data of the debug-port write |
| bg_cmd | input | 1 | BACKGROUND command received (pulse) |
| tag_hit | input | 1 | Tagged instruction about to execute (pulse) |
| bgnd_op | input | 1 | Breakpoint opcode executed (pulse) |
| insn_bound | input | 1 | Instruction boundary strobe |
| go_cmd | input | 1 | Return-to-user command (pulse) |
| cpu_addr | input | 16 | Current CPU bus address for overlay decode |
| dbg_enable | output | 1 | Enable flag |
| dbg_active | output | 1 | Debug state active |
| map_en | output | 1 | Top-page overlay enabled |
| map_hit | output | 1 | Current address falls in the overlaid page |
| ctrl_hit | output | 1 | Current address falls in the control-register window |
| freeze | output | 1 | Peripheral freeze |
| ign_busy | output | 1 | Refused-request delay in progress |

## Verification
The registered results arrive one clock edge after their cause. This covers the flag after a write, debug state after a tag or breakpoint opcode, and the first busy cycle after a refused request. The boundary-timed results, entry on BACKGROUND and exit on return, arrive one edge after the qualifying boundary. The bench drives inputs just after a falling edge and samples just before the next one, so each expectation is checked after exactly one rising edge. It places a boundary in the command cycle to show that this boundary is skipped. The busy window is measured by counting sampled cycles against IGN_CYCLES. The overlay decodes are combinational and are checked a short delay after `cpu_addr` changes, over all 256 offsets of the top page and of two other pages, in both states.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TAG  = 2'd1,
    SRC_BGND = 2'd2,
    SRC_BG   = 2'd3
  } entry_src_e;

  // number of bits needed to hold values 0..n
  function automatic int cnt_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) <= n) b++;
    return b;
  endfunction

  // address lies in the page whose upper bits are all ones
  function automatic logic top_page(input logic [31:0] addr, input int addr_w,
                                    input int page_bits);
    logic ok;
    ok = 1'b1;
    for (int i = page_bits; i < addr_w; i++) ok &= addr[i];
    return ok;
  endfunction

  // offset within the page, for the control window compare
  function automatic logic [31:0] page_offset(input logic [31:0] addr,
                                              input int page_bits);
    logic [31:0] m;
    m = (32'd1 << page_bits) - 32'd1;
    return addr & m;
  endfunction

endpackage

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFF01,
  parameter int ENABLE_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_special,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              enable,
  output logic              status_wr
);
  assign status_wr = reg_wr && (reg_addr == STATUS_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)         enable <= boot_special;
    else if (status_wr) enable <= reg_wdata[ENABLE_BIT];
  end
endmodule

// File: rtl/dbg_ignore_timer.sv
module dbg_ignore_timer #(
  parameter int IGN_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  import dbg_entry_pkg::*;
  localparam int CW = cnt_bits(IGN_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(IGN_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/dbg_entry_seq.sv
module dbg_entry_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_special,
  input  logic enable,
  input  logic busy,
  input  logic tag_hit,
  input  logic bgnd_op,
  input  logic bg_cmd,
  input  logic insn_bound,
  input  logic go_cmd,
  output logic active,
  output logic ev_enter,
  output logic ev_exit,
  output logic ev_reject,
  output dbg_entry_pkg::entry_src_e ev_src
);
  import dbg_entry_pkg::*;

  logic bg_pend, go_pend;
  logic any_req, imm_req, bg_take;

  assign any_req  = tag_hit || bgnd_op || bg_cmd;
  assign imm_req  = enable && !active && (tag_hit || bgnd_op);
  assign bg_take  = !active && bg_pend && insn_bound;
  assign ev_enter = imm_req || bg_take;
  assign ev_exit  = active && go_pend && insn_bound;
  assign ev_reject = !enable && !active && !busy && any_req;

  always_comb begin
    ev_src = SRC_NONE;
    if (enable && !active && tag_hit)       ev_src = SRC_TAG;
    else if (enable && !active && bgnd_op)  ev_src = SRC_BGND;
    else if (bg_take)                       ev_src = SRC_BG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= boot_special;
      bg_pend <= 1'b0;
      go_pend <= 1'b0;
    end else begin
      if (ev_enter)     active <= 1'b1;
      else if (ev_exit) active <= 1'b0;

      if (ev_enter)                            bg_pend <= 1'b0;
      else if (bg_cmd && enable && !active)    bg_pend <= 1'b1;

      if (ev_exit)                             go_pend <= 1'b0;
      else if (go_cmd && active)               go_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_map_decode.sv
module dbg_map_decode #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 8,
  parameter int CTRL_LAST = 6
) (
  input  logic              active,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              map_hit,
  output logic              ctrl_hit
);
  import dbg_entry_pkg::*;
  logic [31:0] a32;
  logic in_page;

  assign a32      = 32'(cpu_addr);
  assign in_page  = top_page(a32, ADDR_W, PAGE_BITS);
  assign map_hit  = active && in_page;
  assign ctrl_hit = map_hit && (page_offset(a32, PAGE_BITS) <= 32'(CTRL_LAST));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFF01,
  parameter int ENABLE_BIT  = 7,
  parameter int IGN_CYCLES  = 16,
  parameter int PAGE_BITS   = 8,
  parameter int CTRL_LAST   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_special,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              bg_cmd,
  input  logic              tag_hit,
  input  logic              bgnd_op,
  input  logic              insn_bound,
  input  logic              go_cmd,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              dbg_enable,
  output logic              dbg_active,
  output logic              map_en,
  output logic              map_hit,
  output logic              ctrl_hit,
  output logic              freeze,
  output logic              ign_busy
);
  import dbg_entry_pkg::*;

  logic       status_wr;
  logic       ev_enter, ev_exit, ev_reject;
  entry_src_e ev_src;

  dbg_status_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_ADDR(STATUS_ADDR), .ENABLE_BIT(ENABLE_BIT)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .boot_special(boot_special),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .enable(dbg_enable), .status_wr(status_wr)
  );

  dbg_ignore_timer #(.IGN_CYCLES(IGN_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(ev_reject), .busy(ign_busy)
  );

  dbg_entry_seq u_seq (
    .clk(clk), .rst_n(rst_n), .boot_special(boot_special),
    .enable(dbg_enable), .busy(ign_busy),
    .tag_hit(tag_hit), .bgnd_op(bgnd_op), .bg_cmd(bg_cmd),
    .insn_bound(insn_bound), .go_cmd(go_cmd),
    .active(dbg_active), .ev_enter(ev_enter), .ev_exit(ev_exit),
    .ev_reject(ev_reject), .ev_src(ev_src)
  );

  dbg_map_decode #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .CTRL_LAST(CTRL_LAST)
  ) u_map (
    .active(dbg_active), .cpu_addr(cpu_addr),
    .map_hit(map_hit), .ctrl_hit(ctrl_hit)
  );

  assign map_en = dbg_active;
  assign freeze = dbg_active;
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFF01,
  parameter int ENABLE_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              tag_hit,
  input logic              bgnd_op,
  input logic              bg_cmd,
  input logic              insn_bound,
  input logic              dbg_enable,
  input logic              dbg_active,
  input logic              map_hit,
  input logic              map_en,
  input logic              ign_busy,
  input logic              ev_reject,
  input logic              ev_enter
);
  assert_status_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STATUS_ADDR) |=> (dbg_enable == $past(reg_wdata[ENABLE_BIT])));

  assert_tag_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_enable && !dbg_active && tag_hit) |=> dbg_active);

  assert_bgnd_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_enable && !dbg_active && bgnd_op) |=> dbg_active);

  assert_entry_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_active) |-> $past(tag_hit || bgnd_op || insn_bound));

  assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (ign_busy && !dbg_active));

  assert_no_enter_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter |-> !ev_reject);

  assert_overlay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    map_hit |-> map_en);

  assert_exit_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_active) |-> $past(insn_bound));
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STATUS_ADDR(STATUS_ADDR), .ENABLE_BIT(ENABLE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tag_hit(tag_hit), .bgnd_op(bgnd_op),
  .bg_cmd(bg_cmd), .insn_bound(insn_bound), .dbg_enable(dbg_enable),
  .dbg_active(dbg_active), .map_hit(map_hit), .map_en(map_en),
  .ign_busy(ign_busy), .ev_reject(ev_reject), .ev_enter(ev_enter)
);

// File: tb/dbg_entry_ctrl_test.sv
`timescale 1ns/1ps
module dbg_entry_ctrl_test;
  localparam int IGN = 16;

  logic clk = 1'b0;
  logic rst_n, boot_special, reg_wr, bg_cmd, tag_hit, bgnd_op, insn_bound, go_cmd;
  logic [15:0] reg_addr, cpu_addr;
  logic [7:0]  reg_wdata;
  logic dbg_enable, dbg_active, map_en, map_hit, ctrl_hit, freeze, ign_busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .boot_special(boot_special),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bg_cmd(bg_cmd), .tag_hit(tag_hit), .bgnd_op(bgnd_op),
    .insn_bound(insn_bound), .go_cmd(go_cmd), .cpu_addr(cpu_addr),
    .dbg_enable(dbg_enable), .dbg_active(dbg_active), .map_en(map_en),
    .map_hit(map_hit), .ctrl_hit(ctrl_hit), .freeze(freeze), .ign_busy(ign_busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; bg_cmd = 0; tag_hit = 0; bgnd_op = 0; insn_bound = 0; go_cmd = 0;
  endtask

  task automatic do_reset(input logic special);
    boot_special = special; rst_n = 0; idle();
    reg_addr = '0; reg_wdata = '0; cpu_addr = '0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic boundary();
    insn_bound = 1; tick(); insn_bound = 0;
  endtask

  task automatic leave();
    go_cmd = 1; tick(); go_cmd = 0;
    boundary();
    chk("R8 exit at boundary", dbg_active, 0);
  endtask

  // measure refused-request busy window; src 0 tag, 1 opcode, 2 background
  task automatic refuse(input int src, input int retry_at);
    int n;
    tag_hit = (src == 0); bgnd_op = (src == 1); bg_cmd = (src == 2);
    tick(); idle();
    n = 0;
    while (ign_busy && n < 4 * IGN) begin
      if (n == retry_at) begin
        tag_hit = 1; bgnd_op = 1;
      end
      chk("R5 no entry while disabled", dbg_active, 0);
      n++;
      tick(); idle();
    end
    chk("R5 busy length", n, IGN);
    boundary();
    chk("R5 background dropped when disabled", dbg_active, 0);
  endtask

  task automatic sweep(input logic act);
    logic [15:0] pages [3];
    pages[0] = 16'hFF00; pages[1] = 16'hFE00; pages[2] = 16'h0000;
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < 256; o++) begin
        int hit, chit;
        cpu_addr = pages[p] | 16'(o);
        #0.5;
        hit  = (act && p == 0) ? 1 : 0;
        chit = (hit == 1 && o <= 6) ? 1 : 0;
        chk("R7 map_hit", map_hit, hit);
        chk("R7 ctrl_hit", ctrl_hit, chit);
      end
    end
    chk("R7 map_en", map_en, act);
    chk("R9 freeze", freeze, act);
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    chk("R6 normal boot inactive", dbg_active, 0);
    chk("R6 normal boot disabled", dbg_enable, 0);
    chk("R5 reset not busy", ign_busy, 0);
    chk("R9 reset freeze", freeze, 0);
    sweep(1'b0);

    refuse(0, -1);
    refuse(1, 5);
    refuse(2, 0);

    wr(16'hFF00, 8'hFF); chk("R1 other address ignored", dbg_enable, 0);
    wr(16'hFF01, 8'h7F); chk("R1 bit7 clear keeps disabled", dbg_enable, 0);
    wr(16'hFF01, 8'h80); chk("R1 enable set", dbg_enable, 1);
    wr(16'hFF02, 8'h00); chk("R1 other address ignored", dbg_enable, 1);

    tag_hit = 1; tick(); idle();
    chk("R2 tag entry next cycle", dbg_active, 1);
    chk("R9 freeze while active", freeze, 1);
    sweep(1'b1);
    go_cmd = 1; insn_bound = 1; tick(); idle();
    chk("R8 same-cycle boundary skipped", dbg_active, 1);
    tick(); chk("R8 waits for boundary", dbg_active, 1);
    boundary();
    chk("R8 exit at boundary", dbg_active, 0);
    chk("R9 freeze drops", freeze, 0);

    bgnd_op = 1; tick(); idle();
    chk("R3 opcode entry next cycle", dbg_active, 1);
    leave();

    bg_cmd = 1; insn_bound = 1; tick(); idle();
    chk("R4 same-cycle boundary skipped", dbg_active, 0);
    tick(); tick();
    chk("R4 pending without boundary", dbg_active, 0);
    boundary();
    chk("R4 entry after boundary", dbg_active, 1);
    chk("R5 no busy when enabled", ign_busy, 0);
    leave();

    wr(16'hFF01, 8'h00); chk("R1 enable cleared", dbg_enable, 0);
    tag_hit = 1; tick(); idle();
    chk("R5 refused after clear", dbg_active, 0);
    chk("R5 busy after clear", ign_busy, 1);

    do_reset(1'b1);
    chk("R6 special boot active", dbg_active, 1);
    chk("R6 special boot enabled", dbg_enable, 1);
    chk("R7 special boot map", map_en, 1);
    leave();
    tag_hit = 1; tick(); idle();
    chk("R2 re-entry after special boot", dbg_active, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule